// File: doc/BRIEF.md
# Grouped Event Counter Monitor

This block counts hardware events for performance analysis. It holds a set of 32-bit event counters, split into equal groups. Each counter has its own event-type field that picks one of the `events` input strobes. A counter advances by one on a clock cycle when all of the following are true:

- the picked strobe is high;
- the global enable is set;
- the enable of the counter's group is set;
- the counter's own enable is set.

When a counter wraps, it raises a sticky overflow flag. The `irq` output is a level signal. It stays high while any flagged counter also has its interrupt enable set.

Software reaches the block through a single-cycle register port. A write lands on the clock edge where `wrEn` is high. A read strobe loads `rdData`, which then holds that value from the next cycle on. The per-counter enables are never written directly. Software changes them through paired write-one-to-set and write-one-to-clear registers, and the overflow flags are cleared by writing one.

Top module: `evmon_top`

## Requirements
- R1: The configuration register (byte 0x004) reads the total counter count in bits [7:0] and the group count in bits [31:24]. Each group register (0x040 + 4·g) reports the counters per group in bits [27:24]. Writes do not change these fields.
- R2: Bit 0 of the main control register (0x000) is the global count enable. It reads back as written and is 0 after reset.
- R3: Writing 1 to bit 1 of the main control register zeroes every counter on that edge. Bit 1 always reads 0.
- R4: Bit 11 of group register g is that group's enable. It reads back as written, and while it is 0 no counter of the group advances.
- R5: Counter n is bit n mod 32 of word n div 32. Writing a 1 bit to the enable-set words (0x100 + 4·w) enables that counter. Writing a 1 bit to the enable-clear words (0x140 + 4·w) disables it. Bits written as 0 change nothing. Reading either word returns the current enables.
- R6: Interrupt enables behave the same way, with set words at 0x180 + 4·w and clear words at 0x1C0 + 4·w.
- R7: A counter adds 1 on each cycle where its selected event strobe is high and the global, group and counter enables are all 1. The event-type register (0x600 + 4·n, bits [7:0]) holds the strobe index. An index at or above the number of strobes never counts.
- R8: Writing the count register (0x400 + 4·n) loads that counter. On the same edge, the write takes priority over an increment.
- R9: An increment from all-ones to zero sets the counter's overflow flag (0x200 + 4·w, bit n mod 32). The flag stays set until software clears it.
- R10: Writing the overflow word clears only the flags whose bits are written as 1.
- R11: `irq` is high exactly when some counter has both its overflow flag and its interrupt enable set.
- R12: `rdData` takes the addressed value on the edge where `rdEn` is high. Unused, unaligned or out-of-range addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Byte address of the register access |
| wrData | input | 32 | Write data |
| wrEn | input | 1 | Write strobe, one cycle per write |
| rdEn | input | 1 | Read strobe, one cycle per read |
| rdData | output | 32 | Read data, registered |
| events | input | NUM_EVENTS | Event strobes, sampled every cycle |
| irq | output | 1 | Level overflow interrupt |

## Verification
The assertions assume three things about the inputs:

- At most one register access happens per cycle.
- `wrEn` and `rdEn` stay low during reset.
- The event strobes are only meaningful when sampled on the clock edge.

The stimulus changes `addr`, `wrData`, the strobes and `events` only on the falling edge, and it never issues a read and a write together. The wrap check starts from a count that software preloads next to all-ones. This lets the flag path be reached in two event cycles instead of four billion.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned CNT_W    = 32;
  localparam int unsigned IDX_W    = 8;
  localparam int unsigned EVFLD_W  = 8;
  localparam int unsigned GRP_EN_BIT = 11;

  localparam logic [ADDR_W-1:0] A_CTRL  = 12'h000;
  localparam logic [ADDR_W-1:0] A_CFG   = 12'h004;
  localparam logic [ADDR_W-1:0] A_GRP   = 12'h040;
  localparam logic [ADDR_W-1:0] A_ENSET = 12'h100;
  localparam logic [ADDR_W-1:0] A_ENCLR = 12'h140;
  localparam logic [ADDR_W-1:0] A_IESET = 12'h180;
  localparam logic [ADDR_W-1:0] A_IECLR = 12'h1C0;
  localparam logic [ADDR_W-1:0] A_OVF   = 12'h200;
  localparam logic [ADDR_W-1:0] A_CNT   = 12'h400;
  localparam logic [ADDR_W-1:0] A_EVT   = 12'h600;

  // strobes from the register control to the counter datapath
  typedef struct packed {
    logic              clrAll;
    logic              cntWr;
    logic [IDX_W-1:0]  cntIdx;
    logic              ovfClr;
    logic [IDX_W-1:0]  ovfWord;
    logic [DATA_W-1:0] data;
  } dpStrobe_t;
endpackage

// File: rtl/evmon_ctrl.sv
module evmon_ctrl
  import evmon_pkg::*;
#(
  parameter int unsigned NUM_GROUPS     = 2,
  parameter int unsigned CNTS_PER_GROUP = 4,
  parameter int unsigned NUM_EVENTS     = 4
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [ADDR_W-1:0]                     addr,
  input  logic [DATA_W-1:0]                     wrData,
  input  logic                                  wrEn,
  input  logic                                  rdEn,
  output logic [DATA_W-1:0]                     rdData,
  input  logic [NUM_EVENTS-1:0]                 events,
  input  logic [NUM_GROUPS*CNTS_PER_GROUP-1:0][CNT_W-1:0] counts,
  input  logic [NUM_GROUPS*CNTS_PER_GROUP-1:0]  ovf,
  output logic [NUM_GROUPS*CNTS_PER_GROUP-1:0]  irqEn,
  output logic [NUM_GROUPS*CNTS_PER_GROUP-1:0]  incMask,
  output dpStrobe_t                             strb
);
  localparam int unsigned NUM_CNT   = NUM_GROUPS * CNTS_PER_GROUP;
  localparam int unsigned NUM_WORDS = (NUM_CNT + 31) / 32;
  localparam int unsigned W0_BITS   = (NUM_CNT < 32) ? NUM_CNT : 32;

  logic                    globalEn;
  logic [NUM_GROUPS-1:0]   grpEn;
  logic [NUM_CNT-1:0]      cntEn;
  logic [NUM_CNT-1:0][EVFLD_W-1:0] evtSel;
  logic [DATA_W-1:0]       rdNext;

  function automatic logic inRange(input logic [ADDR_W-1:0] a,
                                   input logic [ADDR_W-1:0] base,
                                   input int unsigned n);
    return (a[1:0] == 2'b00) && (32'(a) >= 32'(base)) &&
           (32'(a) < 32'(base) + n * 32'd4);
  endfunction

  function automatic logic [IDX_W-1:0] idxOf(input logic [ADDR_W-1:0] a,
                                             input logic [ADDR_W-1:0] base);
    logic [ADDR_W-1:0] off;
    off = a - base;
    return off[IDX_W+1:2];
  endfunction

  logic hitCtrl, hitCfg, hitGrp, hitEnSet, hitEnClr, hitIeSet, hitIeClr;
  logic hitOvf, hitCnt, hitEvt;
  logic [IDX_W-1:0] idx;

  always_comb begin
    hitCtrl  = inRange(addr, A_CTRL, 1);
    hitCfg   = inRange(addr, A_CFG, 1);
    hitGrp   = inRange(addr, A_GRP, NUM_GROUPS);
    hitEnSet = inRange(addr, A_ENSET, NUM_WORDS);
    hitEnClr = inRange(addr, A_ENCLR, NUM_WORDS);
    hitIeSet = inRange(addr, A_IESET, NUM_WORDS);
    hitIeClr = inRange(addr, A_IECLR, NUM_WORDS);
    hitOvf   = inRange(addr, A_OVF, NUM_WORDS);
    hitCnt   = inRange(addr, A_CNT, NUM_CNT);
    hitEvt   = inRange(addr, A_EVT, NUM_CNT);
    idx = '0;
    if (hitGrp)                idx = idxOf(addr, A_GRP);
    else if (hitEnSet)         idx = idxOf(addr, A_ENSET);
    else if (hitEnClr)         idx = idxOf(addr, A_ENCLR);
    else if (hitIeSet)         idx = idxOf(addr, A_IESET);
    else if (hitIeClr)         idx = idxOf(addr, A_IECLR);
    else if (hitOvf)           idx = idxOf(addr, A_OVF);
    else if (hitCnt)           idx = idxOf(addr, A_CNT);
    else if (hitEvt)           idx = idxOf(addr, A_EVT);
  end

  // strobes toward the datapath
  always_comb begin
    strb.clrAll  = wrEn && hitCtrl && wrData[1];
    strb.cntWr   = wrEn && hitCnt;
    strb.cntIdx  = idx;
    strb.ovfClr  = wrEn && hitOvf;
    strb.ovfWord = idx;
    strb.data    = wrData;
  end

  // event selection and three-level gating
  always_comb begin
    for (int n = 0; n < NUM_CNT; n++) begin
      logic hit;
      hit = 1'b0;
      for (int e = 0; e < NUM_EVENTS; e++)
        if (evtSel[n] == EVFLD_W'(e)) hit = hit | events[e];
      incMask[n] = globalEn && grpEn[n / CNTS_PER_GROUP] && cntEn[n] && hit;
    end
  end

  // read mux
  always_comb begin
    rdNext = '0;
    if (hitCtrl) begin
      rdNext[0] = globalEn;
    end else if (hitCfg) begin
      rdNext[31:24] = 8'(NUM_GROUPS);
      rdNext[7:0]   = 8'(NUM_CNT);
    end else if (hitGrp) begin
      for (int g = 0; g < NUM_GROUPS; g++)
        if (idx == IDX_W'(g)) begin
          rdNext[27:24]      = 4'(CNTS_PER_GROUP);
          rdNext[GRP_EN_BIT] = grpEn[g];
        end
    end else if (hitEnSet || hitEnClr) begin
      for (int n = 0; n < NUM_CNT; n++)
        if (idx == IDX_W'(n / 32)) rdNext[n % 32] = cntEn[n];
    end else if (hitIeSet || hitIeClr) begin
      for (int n = 0; n < NUM_CNT; n++)
        if (idx == IDX_W'(n / 32)) rdNext[n % 32] = irqEn[n];
    end else if (hitOvf) begin
      for (int n = 0; n < NUM_CNT; n++)
        if (idx == IDX_W'(n / 32)) rdNext[n % 32] = ovf[n];
    end else if (hitCnt) begin
      for (int n = 0; n < NUM_CNT; n++)
        if (idx == IDX_W'(n)) rdNext = DATA_W'(counts[n]);
    end else if (hitEvt) begin
      for (int n = 0; n < NUM_CNT; n++)
        if (idx == IDX_W'(n)) rdNext[EVFLD_W-1:0] = evtSel[n];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      grpEn    <= '0;
      cntEn    <= '0;
      irqEn    <= '0;
      evtSel   <= '0;
      rdData   <= '0;
    end else begin
      if (wrEn && hitCtrl) globalEn <= wrData[0];
      for (int g = 0; g < NUM_GROUPS; g++)
        if (wrEn && hitGrp && idx == IDX_W'(g)) grpEn[g] <= wrData[GRP_EN_BIT];
      for (int n = 0; n < NUM_CNT; n++) begin
        if (wrEn && idx == IDX_W'(n / 32) && wrData[n % 32]) begin
          if (hitEnSet) cntEn[n] <= 1'b1;
          if (hitEnClr) cntEn[n] <= 1'b0;
          if (hitIeSet) irqEn[n] <= 1'b1;
          if (hitIeClr) irqEn[n] <= 1'b0;
        end
        if (wrEn && hitEvt && idx == IDX_W'(n)) evtSel[n] <= wrData[EVFLD_W-1:0];
      end
      if (rdEn) rdData <= rdNext;
    end
  end

  // R5: a set write leaves every written-one bit of word 0 enabled
  p_enset_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_ENSET) |=>
      ((cntEn[W0_BITS-1:0] & $past(wrData[W0_BITS-1:0])) == $past(wrData[W0_BITS-1:0])));

  // R6: a clear write leaves every written-one bit of word 0 disabled
  p_ieclr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_IECLR) |=>
      ((irqEn[W0_BITS-1:0] & $past(wrData[W0_BITS-1:0])) == '0));

  // R2: global enable follows a control write
  p_global_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_CTRL) |=> (globalEn == $past(wrData[0])));
endmodule

// File: rtl/evmon_datapath.sv
module evmon_datapath
  import evmon_pkg::*;
#(
  parameter int unsigned NUM_CNT = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  dpStrobe_t                       strb,
  input  logic [NUM_CNT-1:0]              incMask,
  output logic [NUM_CNT-1:0][CNT_W-1:0]   counts,
  output logic [NUM_CNT-1:0]              ovf
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      counts <= '0;
      ovf    <= '0;
    end else begin
      for (int n = 0; n < NUM_CNT; n++) begin
        logic wrHere, wrap;
        wrHere = strb.cntWr && (strb.cntIdx == IDX_W'(n));
        wrap   = incMask[n] && (counts[n] == ALL_ONES) && !strb.clrAll && !wrHere;
        if (strb.clrAll)     counts[n] <= '0;
        else if (wrHere)     counts[n] <= strb.data[CNT_W-1:0];
        else if (incMask[n]) counts[n] <= counts[n] + 1'b1;
        // a new wrap outranks a clear on the same edge
        if (wrap)
          ovf[n] <= 1'b1;
        else if (strb.ovfClr && strb.ovfWord == IDX_W'(n / 32) && strb.data[n % 32])
          ovf[n] <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    // R3: clear-all strobe leaves the counter at zero
    p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
      strb.clrAll |=> (counts[i] == '0));
    // R9: wrapping increment raises the sticky flag
    p_wrap_r9: assert property (@(posedge clk) disable iff (!rstN)
      (incMask[i] && counts[i] == ALL_ONES && !strb.clrAll && !strb.cntWr) |=> ovf[i]);
    // R7: no gate open and no write means the count holds
    p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
      (!incMask[i] && !strb.clrAll && !strb.cntWr) |=> $stable(counts[i]));
  end
endmodule

// File: rtl/evmon_top.sv
module evmon_top
  import evmon_pkg::*;
#(
  parameter int unsigned NUM_GROUPS     = 2,
  parameter int unsigned CNTS_PER_GROUP = 4,
  parameter int unsigned NUM_EVENTS     = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  wrEn,
  input  logic                  rdEn,
  output logic [DATA_W-1:0]     rdData,
  input  logic [NUM_EVENTS-1:0] events,
  output logic                  irq
);
  localparam int unsigned NUM_CNT = NUM_GROUPS * CNTS_PER_GROUP;

  dpStrobe_t                       strb;
  logic [NUM_CNT-1:0]              incMask;
  logic [NUM_CNT-1:0]              irqEn;
  logic [NUM_CNT-1:0]              ovf;
  logic [NUM_CNT-1:0][CNT_W-1:0]   counts;

  evmon_ctrl #(
    .NUM_GROUPS(NUM_GROUPS), .CNTS_PER_GROUP(CNTS_PER_GROUP), .NUM_EVENTS(NUM_EVENTS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn),
    .rdData(rdData), .events(events), .counts(counts), .ovf(ovf), .irqEn(irqEn),
    .incMask(incMask), .strb(strb)
  );

  evmon_datapath #(.NUM_CNT(NUM_CNT)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .incMask(incMask), .counts(counts), .ovf(ovf)
  );

  assign irq = |(ovf & irqEn);

  // R11: an interrupt always has a flag behind it
  p_irq_flag_r11: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (ovf != '0));
endmodule

// File: tb/evmon_top_tb_top.sv
module evmon_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 2, CPG = 4, NE = 4, NC = NG * CPG;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [31:0] rdData;
  logic [NE-1:0] events = '0;
  logic        irq;
  int checks = 0, errors = 0;
  logic [31:0] expCnt [NC];
  logic [31:0] got;

  always #(CLK_PERIOD / 2) clk = ~clk;

  evmon_top #(.NUM_GROUPS(NG), .CNTS_PER_GROUP(CPG), .NUM_EVENTS(NE)) dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn),
    .rdData(rdData), .events(events), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0; d = rdData;
  endtask

  function automatic logic [3:0] pat(input int c);
    return 4'((c * 5 + 3) & 15);
  endfunction

  task automatic runEvents(input int cycles, input logic [NC-1:0] live);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk); events = pat(c);
      for (int n = 0; n < NC; n++)
        if (live[n] && n != 7 && pat(c)[n % 4]) expCnt[n] = expCnt[n] + 1;
    end
    @(negedge clk); events = '0;
  endtask

  task automatic checkCounts(input string req);
    for (int n = 0; n < NC; n++) begin
      rd(12'h400 + 12'(4 * n), got);
      chk(req, got, expCnt[n]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int n = 0; n < NC; n++) expCnt[n] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R11 reset irq", {31'b0, irq}, 32'h0);
    // R1 configuration and group counts, read-only
    rd(12'h004, got); chk("R1 cfg", got, 32'h0200_0008);
    wr(12'h004, 32'h0);
    rd(12'h004, got); chk("R1 cfg write ignored", got, 32'h0200_0008);
    rd(12'h040, got); chk("R1 group0", got, 32'h0400_0000);
    rd(12'h044, got); chk("R1 group1", got, 32'h0400_0000);
    rd(12'h000, got); chk("R2 reset ctrl", got, 32'h0);
    checkCounts("R7 reset counts");
    // R12 unused addresses
    rd(12'h008, got); chk("R12 gap", got, 32'h0);
    rd(12'h048, got); chk("R12 group out of range", got, 32'h0);
    rd(12'h104, got); chk("R12 word out of range", got, 32'h0);
    rd(12'h420, got); chk("R12 counter out of range", got, 32'h0);
    rd(12'h402, got); chk("R12 unaligned", got, 32'h0);
    // R5 set/clear semantics
    wr(12'h100, 32'h05);
    rd(12'h100, got); chk("R5 set", got, 32'h05);
    wr(12'h100, 32'h02);
    rd(12'h140, got); chk("R5 set keeps others", got, 32'h07);
    wr(12'h140, 32'h04);
    rd(12'h100, got); chk("R5 clear", got, 32'h03);
    wr(12'h140, 32'h0);
    rd(12'h140, got); chk("R5 zero write no effect", got, 32'h03);
    // R6 interrupt enable pair
    wr(12'h180, 32'hA0);
    rd(12'h180, got); chk("R6 set", got, 32'hA0);
    wr(12'h1C0, 32'h20);
    rd(12'h1C0, got); chk("R6 clear", got, 32'h80);
    wr(12'h1C0, 32'hFF);
    // R7 event selection; counter 7 gets an out-of-range type
    for (int n = 0; n < NC; n++)
      wr(12'h600 + 12'(4 * n), (n == 7) ? 32'd9 : 32'(n % 4));
    rd(12'h61C, got); chk("R7 type readback", got, 32'd9);
    wr(12'h100, 32'hFF);
    wr(12'h040, 32'h800);
    wr(12'h044, 32'h800);
    rd(12'h040, got); chk("R4 group enable readback", got, 32'h0400_0800);
    runEvents(4, '0);
    checkCounts("R2 global off holds");
    wr(12'h000, 32'h1);
    rd(12'h000, got); chk("R2 ctrl readback", got, 32'h1);
    runEvents(32, 8'hFF);
    checkCounts("R7 all enabled sweep");
    // R4 group 1 off, counter 1 off
    wr(12'h044, 32'h0);
    wr(12'h140, 32'h02);
    runEvents(16, 8'h0D);
    checkCounts("R4 group and counter gating");
    // R3 clear all, global kept on
    wr(12'h000, 32'h3);
    for (int n = 0; n < NC; n++) expCnt[n] = '0;
    checkCounts("R3 clear all");
    rd(12'h000, got); chk("R3 bit1 reads zero", got, 32'h1);
    // R8 counter load
    wr(12'h414, 32'h0000_1234);
    rd(12'h414, got); chk("R8 counter load", got, 32'h0000_1234);
    // R9 wrap of counter 3 (type 3, group 0)
    wr(12'h40C, 32'hFFFF_FFFE);
    @(negedge clk); events = 4'h8;
    @(negedge clk); events = 4'h8;
    @(negedge clk); events = 4'h0;
    rd(12'h40C, got); chk("R9 wrapped count", got, 32'h0);
    rd(12'h200, got); chk("R9 flag set", got, 32'h08);
    chk("R11 flag without enable", {31'b0, irq}, 32'h0);
    wr(12'h180, 32'h08);
    chk("R11 irq raised", {31'b0, irq}, 32'h1);
    wr(12'h200, 32'h01);
    rd(12'h200, got); chk("R10 other bit no effect", got, 32'h08);
    chk("R9 flag sticky irq", {31'b0, irq}, 32'h1);
    wr(12'h200, 32'h08);
    rd(12'h200, got); chk("R10 flag cleared", got, 32'h0);
    chk("R11 irq dropped", {31'b0, irq}, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule